// File: doc/BRIEF.md
# Shadow-Store Controller for Nonvolatile SRAM

This block fronts a small volatile SRAM that has a nonvolatile shadow copy. It uses three inputs to pick one of four operating modes: an active-low chip select, an active-low write enable, and the level sensed on an open-drain store strobe line. The modes are standby, read, write and store. The block also keeps a flag that records whether the SRAM has been written since the last nonvolatile cycle. A store copies the whole SRAM into the shadow array after a fixed latency, and only when that flag is set. A recall pulse loads the SRAM back from the shadow array.

A store can start in two ways. The first is an external agent pulling the strobe line low. The second is a supply-droop flag, which acts only while automatic store is enabled. At the start of a store the block pulls the line low itself for a short pulse. For a droop-started store it then checks that the line actually went low. If the line stayed high, for example because something outside held it high, the block drops the attempt. After any strobe-started store, including one that was skipped, the block refuses reads and writes until the line is released.

The line is modelled as two ports: a drive-low enable going out and a sensed level coming in. The sensed level passes through a two-flop synchroniser before the block uses it.

Top module: `nv_shadow_ctrl`

## Requirements
- R1: Mode selection uses the synchronised strobe level, which lags the line by two clock cycles. While that level is high and the block is idle, `cs_n`=1 is standby: `rdata_oe` is 0 and the SRAM is not written, whatever `we_n`, `addr` and `wdata` are.
- R2: Idle, synchronised strobe high, `cs_n`=0 and `we_n`=1 is a read: `rdata_oe` is 1 and `rdata` shows the SRAM word at `addr` in the same cycle.
- R3: Idle, synchronised strobe high, `cs_n`=0 and `we_n`=0 is a write: at the clock edge the SRAM word at `addr` takes `wdata`, and the modified flag is set.
- R4: While the synchronised strobe is low, `rdata_oe` is 0 and no SRAM write takes effect, whatever `cs_n`, `we_n` and `addr` are.
- R5: When the strobe goes low and the modified flag is set, the block drives the line low, waits for the synchroniser to settle, and copies every SRAM word into the shadow array. The modified flag is then cleared.
- R6: When the strobe goes low and the modified flag is clear, no copy is made. `busy` and `strobe_drive` both stay 0.
- R7: After a strobe-started store completes or is skipped, `rdata_oe` stays 0 and writes are refused until the synchronised strobe returns high.
- R8: `droop`=1 with `auto_en`=1 and the modified flag set starts a store with a drive pulse. If the synchronised strobe is never low during the pulse or the settle window that follows, the drive stops, no copy is made, and the modified flag stays set.
- R9: `droop` has no effect while `auto_en`=0.
- R10: `recall`=1 in an idle, unlocked cycle loads every SRAM word from the shadow array and clears the modified flag. A write in the same cycle is dropped.
- R11: `busy` is high for exactly STORE_CYC consecutive cycles for each copy, and `rdata_oe` is 0 throughout.
- R12: `strobe_drive` is high for exactly PULSE_CYC consecutive cycles at the start of each store attempt, and never at the same time as `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid while rdata_oe is 1 |
| rdata_oe | output | 1 | Read data output enable (0 = high impedance) |
| strobe_in | input | 1 | Sensed level of the open-drain store strobe line |
| strobe_drive | output | 1 | 1 = pull the store strobe line low |
| droop | input | 1 | Supply-droop flag |
| auto_en | input | 1 | Enables droop-started stores |
| recall | input | 1 | Load SRAM from the shadow array |
| busy | output | 1 | High while the shadow copy is in progress |

## Verification
The bench builds the block with PULSE_CYC=3 and STORE_CYC=6 over a 16-word, 8-bit array. With these values the drive pulse is longer than the two-cycle synchroniser, and a full store, including the lockout and its release, takes only a few dozen cycles. That leaves room in one run for a strobe-started store, a skipped store, a droop store that is refused because the line is held high, and a droop store that completes. Each of these can be followed by a recall that shows what the shadow array holds.

// File: rtl/nvs_pkg.sv
// Shared types for the shadow-store controller.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package nvs_pkg;

    // Store sequencer phases
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_SETTLE,
        ST_COPY,
        ST_HOLD
    } seq_state_t;

    // Decoded operating modes
    typedef enum logic [1:0] {
        MD_STANDBY,
        MD_READ,
        MD_WRITE,
        MD_STORE
    } op_mode_t;

endpackage

// File: rtl/nvs_sync.sv
// Multi-flop synchroniser for the sensed strobe level.
// Assumes: STAGES >= 1; output resets to RST_VAL.
module nvs_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            // Purpose: single-stage capture
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= RST_VAL;
                else        chain_q <= d;
            end
        end else begin : g_chain
            // Purpose: shift the level through the flop chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= {STAGES{RST_VAL}};
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/nvs_array.sv
// Behavioural SRAM word array with a shadow nonvolatile copy.
// Assumes: at most one of wr_en, store_do, recall_do matters per cycle;
// store_do copies every word at once, recall_do restores every word.
// Both arrays clear on reset (model only).
module nvs_array #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              store_do,
    input  logic              recall_do,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] sram_q [DEPTH];
    logic [DATA_W-1:0] shadow_q [DEPTH];

    // Purpose: volatile array, written by the port or restored by recall
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n)                            sram_q[i] <= '0;
            else if (recall_do)                    sram_q[i] <= shadow_q[i];
            else if (wr_en && (int'(addr) == i))   sram_q[i] <= wdata;
        end
    end

    // Purpose: shadow array, loaded in one step at the end of a copy
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n)        shadow_q[i] <= '0;
            else if (store_do) shadow_q[i] <= sram_q[i];
        end
    end

    assign rdata = sram_q[addr];
endmodule

// File: rtl/nvs_seq.sv
// Mode decoder and store sequencer.
// Decodes cs_n/we_n/synchronised strobe into an operating mode, keeps the
// modified flag, and runs pulse -> settle -> copy -> hold.
// Assumes: strobe_s is already synchronised; PULSE_CYC, SETTLE_CYC,
// STORE_CYC >= 1.
module nvs_seq
    import nvs_pkg::*;
#(
    parameter int PULSE_CYC  = 2,
    parameter int SETTLE_CYC = 2,
    parameter int STORE_CYC  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic we_n,
    input  logic strobe_s,
    input  logic droop,
    input  logic auto_en,
    input  logic recall,
    output logic wr_en,
    output logic rd_oe,
    output logic store_do,
    output logic recall_do,
    output logic busy,
    output logic drive
);
    localparam int MAX_A = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
    localparam int MAX_C = (STORE_CYC > MAX_A) ? STORE_CYC : MAX_A;
    localparam int CNT_W = $clog2(MAX_C + 1);
    localparam logic [CNT_W-1:0] PULSE_LAST  = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] COPY_LAST   = CNT_W'(STORE_CYC - 1);

    seq_state_t       state_q, state_d;
    op_mode_t         mode;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             low_q, low_d;
    logic             from_q, from_d;
    logic             dirty_q;
    logic             idle_open, take_strobe, take_droop;

    // Purpose: decode the operating mode and the start conditions
    always_comb begin
        idle_open   = (state_q == ST_IDLE) && strobe_s;
        take_strobe = (state_q == ST_IDLE) && !strobe_s;
        take_droop  = idle_open && droop && auto_en && dirty_q;
        recall_do   = idle_open && !take_droop && recall;
        if (!idle_open)  mode = MD_STORE;
        else if (cs_n)   mode = MD_STANDBY;
        else if (we_n)   mode = MD_READ;
        else             mode = MD_WRITE;
        wr_en = (mode == MD_WRITE) && !take_droop && !recall_do;
        rd_oe = (mode == MD_READ);
    end

    // Purpose: next-state logic of the store sequencer
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        low_d    = low_q | !strobe_s;
        from_d   = from_q;
        store_do = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                low_d = 1'b0;
                cnt_d = '0;
                if (take_strobe) begin
                    from_d  = 1'b0;
                    state_d = dirty_q ? ST_PULSE : ST_HOLD;
                end else if (take_droop) begin
                    from_d  = 1'b1;
                    state_d = ST_PULSE;
                end
            end
            ST_PULSE: begin
                if (cnt_q == PULSE_LAST) begin
                    cnt_d   = '0;
                    state_d = ST_SETTLE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_SETTLE: begin
                if (cnt_q == SETTLE_LAST) begin
                    cnt_d   = '0;
                    state_d = (from_q && !low_d) ? ST_IDLE : ST_COPY;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_COPY: begin
                if (cnt_q == COPY_LAST) begin
                    cnt_d    = '0;
                    store_do = 1'b1;
                    state_d  = ST_HOLD;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_HOLD: begin
                if (strobe_s) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Purpose: sequencer registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            low_q   <= 1'b0;
            from_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            low_q   <= low_d;
            from_q  <= from_d;
        end
    end

    // Purpose: modified-since-last-nonvolatile-cycle flag
    always_ff @(posedge clk) begin
        if (!rst_n)                     dirty_q <= 1'b0;
        else if (store_do || recall_do) dirty_q <= 1'b0;
        else if (wr_en)                 dirty_q <= 1'b1;
    end

    assign busy  = (state_q == ST_COPY);
    assign drive = (state_q == ST_PULSE);
endmodule

// File: rtl/nv_shadow_ctrl.sv
// Top of the shadow-store controller: synchroniser, sequencer, arrays.
// Assumes: strobe_in is the raw level of an open-drain line pulled high
// externally; strobe_drive=1 asks the pad to pull it low.
module nv_shadow_ctrl #(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8,
    parameter int PULSE_CYC   = 2,
    parameter int STORE_CYC   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    input  logic              strobe_in,
    output logic              strobe_drive,
    input  logic              droop,
    input  logic              auto_en,
    input  logic              recall,
    output logic              busy
);
    logic strobe_s;
    logic wr_en, store_do, recall_do;

    nvs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (strobe_in),
        .q     (strobe_s)
    );

    nvs_seq #(
        .PULSE_CYC  (PULSE_CYC),
        .SETTLE_CYC (SYNC_STAGES),
        .STORE_CYC  (STORE_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .we_n      (we_n),
        .strobe_s  (strobe_s),
        .droop     (droop),
        .auto_en   (auto_en),
        .recall    (recall),
        .wr_en     (wr_en),
        .rd_oe     (rdata_oe),
        .store_do  (store_do),
        .recall_do (recall_do),
        .busy      (busy),
        .drive     (strobe_drive)
    );

    nvs_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .store_do  (store_do),
        .recall_do (recall_do),
        .rdata     (rdata)
    );
endmodule

// File: rtl/nvs_checker.sv
// Protocol checks for nv_shadow_ctrl, bound into every instance.
// Assumes: strobe_s is the top's synchronised strobe level.
module nvs_checker #(
    parameter int PULSE_CYC = 2,
    parameter int STORE_CYC = 16
) (
    input logic clk,
    input logic rst_n,
    input logic strobe_s,
    input logic rdata_oe,
    input logic busy,
    input logic strobe_drive
);
    localparam logic [15:0] PULSE_LEN = 16'(PULSE_CYC);
    localparam logic [15:0] COPY_LEN  = 16'(STORE_CYC);

    logic [15:0] drv_run, busy_run;

    // Purpose: length of the current drive and busy runs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_run  <= '0;
            busy_run <= '0;
        end else begin
            drv_run  <= strobe_drive ? drv_run + 16'd1 : 16'd0;
            busy_run <= busy ? busy_run + 16'd1 : 16'd0;
        end
    end

    a_r4_low_strobe_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_s |-> !rdata_oe);

    a_r11_busy_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !rdata_oe);

    a_r11_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && busy_run != 16'd0) |-> (busy_run == COPY_LEN));

    a_r12_drive_length: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_drive && drv_run != 16'd0) |-> (drv_run == PULSE_LEN));

    a_r12_drive_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_drive |-> !busy);
endmodule

bind nv_shadow_ctrl nvs_checker #(
    .PULSE_CYC (PULSE_CYC),
    .STORE_CYC (STORE_CYC)
) u_nvs_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobe_s     (strobe_s),
    .rdata_oe     (rdata_oe),
    .busy         (busy),
    .strobe_drive (strobe_drive)
);

// File: tb/test_nv_shadow_ctrl.sv
`timescale 1ns/1ps
module test_nv_shadow_ctrl;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int PC = 3;
    localparam int SC = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          droop = 1'b0, auto_en = 1'b0, recall = 1'b0;
    logic          ext_low = 1'b0, ext_hold = 1'b0;
    logic [DW-1:0] rdata;
    logic          rdata_oe, strobe_drive, busy, strobe_in;

    // open-drain line: external pull-down, internal pull-down, external hold-high
    assign strobe_in = !(ext_low || (strobe_drive && !ext_hold));

    nv_shadow_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PULSE_CYC(PC), .STORE_CYC(SC)) i_nv_shadow_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rdata_oe(rdata_oe), .strobe_in(strobe_in), .strobe_drive(strobe_drive),
        .droop(droop), .auto_en(auto_en), .recall(recall), .busy(busy)
    );

    always #2 clk = ~clk;

    int n_run = 0, n_fail = 0;
    int busy_obs = 0, drv_obs = 0, oe_obs = 0;
    bit finished = 1'b0;

    // reference model: 0 idle, 1 pulse, 2 settle, 3 copy, 4 hold
    int          m_phase, m_cnt;
    bit          m_s1, m_s2, m_low, m_from, m_dirty;
    logic [DW-1:0] m_sram [DEPTH];
    logic [DW-1:0] m_nv [DEPTH];

    always @(posedge clk) begin
        bit line, open, t_droop, t_rec, t_wr;
        if (!rst_n) begin
            m_phase = 0; m_cnt = 0; m_s1 = 1; m_s2 = 1; m_low = 0; m_from = 0; m_dirty = 0;
            for (int i = 0; i < DEPTH; i++) begin m_sram[i] = '0; m_nv[i] = '0; end
        end else begin
            line    = !(ext_low || ((m_phase == 1) && !ext_hold));
            open    = (m_phase == 0) && m_s2;
            t_droop = open && droop && auto_en && m_dirty;
            t_rec   = open && !t_droop && recall;
            t_wr    = open && !cs_n && !we_n && !t_droop && !t_rec;
            case (m_phase)
                0: begin
                    if (!m_s2) begin
                        if (m_dirty) begin m_phase = 1; m_cnt = 0; m_from = 0; m_low = 0; end
                        else m_phase = 4;
                    end else if (t_droop) begin
                        m_phase = 1; m_cnt = 0; m_from = 1; m_low = 0;
                    end
                end
                1: begin
                    if (!m_s2) m_low = 1;
                    if (m_cnt == PC - 1) begin m_phase = 2; m_cnt = 0; end else m_cnt++;
                end
                2: begin
                    if (!m_s2) m_low = 1;
                    if (m_cnt == 1) begin
                        m_phase = (m_from && !m_low) ? 0 : 3;
                        m_cnt = 0;
                    end else m_cnt++;
                end
                3: begin
                    if (m_cnt == SC - 1) begin
                        for (int i = 0; i < DEPTH; i++) m_nv[i] = m_sram[i];
                        m_dirty = 0; m_phase = 4; m_cnt = 0;
                    end else m_cnt++;
                end
                default: if (m_s2) m_phase = 0;
            endcase
            if (t_wr) begin m_sram[addr] = wdata; m_dirty = 1; end
            if (t_rec) begin
                for (int i = 0; i < DEPTH; i++) m_sram[i] = m_nv[i];
                m_dirty = 0;
            end
            m_s2 = m_s1;
            m_s1 = line;
        end
    end

    task automatic chk(input string tag, input int act, input int exp, input string what);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // advance to the next falling edge and compare against the model
    task automatic tick();
        bit exp_oe;
        @(negedge clk);
        exp_oe = (m_phase == 0) && m_s2 && !cs_n && we_n;
        chk("R12", int'(strobe_drive), int'(m_phase == 1), "strobe_drive per cycle");
        chk("R11", int'(busy), int'(m_phase == 3), "busy per cycle");
        chk("R4", int'(rdata_oe), int'(exp_oe), "rdata_oe per cycle");
        if (exp_oe) chk("R2", int'(rdata), int'(m_sram[addr]), "rdata per cycle");
        busy_obs += int'(busy);
        drv_obs  += int'(strobe_drive);
        oe_obs   += int'(rdata_oe);
    endtask

    task automatic clear_obs();
        busy_obs = 0; drv_obs = 0; oe_obs = 0;
    endtask

    task automatic wr(input int a, input int d);
        cs_n = 0; we_n = 0; addr = AW'(a); wdata = DW'(d);
        tick();
        cs_n = 1; we_n = 1;
    endtask

    task automatic rd(input int a, input int exp, input string tag);
        cs_n = 0; we_n = 1; addr = AW'(a);
        #1;
        chk(tag, int'(rdata_oe), 1, "read enable");
        chk(tag, int'(rdata), exp, "read data");
        tick();
        cs_n = 1;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (1000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1: reset state
        chk("R1", int'(busy), 0, "busy after reset");
        chk("R1", int'(strobe_drive), 0, "drive after reset");
        chk("R1", int'(rdata_oe), 0, "oe after reset");

        // R3 writes, R2 reads
        wr(0, 'hA1); wr(1, 'hB2); wr(2, 'hC3); wr(3, 'hD4);
        rd(0, 'hA1, "R2"); rd(1, 'hB2, "R3"); rd(2, 'hC3, "R3"); rd(3, 'hD4, "R3");

        // R1: standby ignores write enable
        cs_n = 1; we_n = 0; addr = 0; wdata = 'hFF;
        tick(); tick();
        chk("R1", int'(rdata_oe), 0, "oe in standby");
        we_n = 1;
        rd(0, 'hA1, "R1");

        // R5/R11/R12: strobe-started store; R4 write attempt while low
        clear_obs();
        ext_low = 1;
        repeat (3) tick();
        cs_n = 0; we_n = 0; addr = 1; wdata = 'hEE;
        repeat (20) tick();
        chk("R11", busy_obs, SC, "busy cycles in store");
        chk("R12", drv_obs, PC, "drive cycles in store");
        we_n = 1; addr = 1;
        #1;
        chk("R7", int'(rdata_oe), 0, "read locked after store");
        tick();
        cs_n = 1;
        ext_low = 0;
        repeat (3) tick();
        rd(1, 'hB2, "R4");

        // R10/R5: recall restores the stored snapshot
        wr(0, 'h11);
        recall = 1; tick(); recall = 0;
        rd(0, 'hA1, "R5");
        rd(3, 'hD4, "R10");

        // R6: nothing modified since recall, store skipped
        clear_obs();
        ext_low = 1;
        repeat (12) tick();
        chk("R6", busy_obs, 0, "busy on skipped store");
        chk("R6", drv_obs, 0, "drive on skipped store");
        cs_n = 0; we_n = 1; addr = 2;
        #1;
        chk("R7", int'(rdata_oe), 0, "read locked after skip");
        tick();
        cs_n = 1;
        ext_low = 0;
        repeat (3) tick();
        rd(2, 'hC3, "R7");

        // R9: droop ignored without auto enable
        wr(2, 'h5A);
        clear_obs();
        droop = 1; auto_en = 0;
        repeat (10) tick();
        droop = 0;
        chk("R9", busy_obs, 0, "busy with auto store off");
        chk("R9", drv_obs, 0, "drive with auto store off");

        // R8: droop store refused because the line is held high
        clear_obs();
        auto_en = 1; ext_hold = 1; droop = 1;
        tick();
        droop = 0;
        repeat (10) tick();
        chk("R8", drv_obs, PC, "drive cycles on aborted droop");
        chk("R8", busy_obs, 0, "busy on aborted droop");
        ext_hold = 0;
        rd(2, 'h5A, "R8");

        // R8: droop store completes (modified flag still set after abort)
        clear_obs();
        droop = 1;
        tick();
        droop = 0;
        repeat (16) tick();
        chk("R8", drv_obs, PC, "drive cycles on droop store");
        chk("R11", busy_obs, SC, "busy cycles on droop store");
        wr(2, 'h00);
        recall = 1; tick(); recall = 0;
        rd(2, 'h5A, "R5");
        rd(0, 'hA1, "R10");

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule